// File: doc/BRIEF.md
# Switch Management Frame Codec

This block carries single register accesses to an Ethernet switch in-band, as short management frames. A command holds a read/write flag, an 18-bit register address, a byte count and up to 32 bits of write data. The block packs the command into a 60-byte frame and streams it out one byte at a time over a valid/ready handshake. It then listens on a byte stream of incoming response frames. A running 31-bit sequence number ties each response to its request.

After a frame is sent, the block waits a set number of clock cycles for a response it can accept. If none arrives, it sends the identical frame again, up to a set number of transmissions in total. For every command it ends with a single `done` pulse. The `error` flag is raised on that same cycle when the access failed. For a successful read, `rdata` carries the value assembled from the response. One write is special: a write to address 0 with data bit 31 set asks the switch to reset itself. That write is reported complete as soon as its frame has left.

Top module: `mgmt_hdr_codec`

## Requirements
- R1: Frame byte 0 is 0x50 OR-ed with the 4-bit port selector parameter (default 0, giving 0x50). Frame byte 1 is 0x05.
- R2: The address is taken as 18 bits with bits 1:0 forced to zero. Byte 2 carries address bits 7:0, byte 3 carries bits 15:8, and byte 4 bits 1:0 carry address bits 17:16. Byte 4 bits 3:2 are zero.
- R3: The byte count is clamped to at most 4 and placed in byte 4 bits 7:4. Byte 5 is 0xB0 for a read and 0xA0 for a write.
- R4: The sequence number is 1 for the first command after reset. It rises by one for each accepted command and does not change on a retransmission. Byte 6 holds `{seq[6:0],0}`, byte 7 holds seq[14:7], byte 8 holds seq[22:15] and byte 9 holds seq[30:23].
- R5: A frame is exactly 60 bytes, and `tx_last` marks byte 59. For a write, bytes 10 onward carry the clamped number of data bytes, least significant first. Every other byte, and every byte from 10 on in a read frame, is zero.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R7: If no response is accepted within the timeout after a frame ends, the same frame is sent again. After the third transmission times out, `done` pulses with `error` high.
- R8: A response is discarded, and the wait goes on, when its length (byte 4 bits 7:4) exceeds 10. It is also discarded when its sequence number, reassembled from bytes 6 to 9 with the packing of R4, is below the current one.
- R9: A read succeeds only when the response sequence number equals the request's and its length equals the clamped request length. `rdata` is then response bytes 10 onward, little-endian, with bytes at or beyond that length read as zero. Any other accepted response ends the read with `error` high and `rdata` zero.
- R10: A write completes, with `error` low, on the first response that is not discarded.
- R11: A write to address 0 (after masking) with data bit 31 set pulses `done` with `error` low, with no response needed.
- R12: After reset, `cmd_ready` is high while `tx_valid` and `done` are low. `cmd_ready` is high only while no command is in flight. Responses that arrive when no response is awaited have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken on valid |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 18 | Register byte address |
| cmd_len | input | 4 | Byte count, clamped to 4 |
| cmd_wdata | input | 32 | Write data |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final frame byte |
| rx_valid | input | 1 | Response byte valid |
| rx_data | input | 8 | Response byte |
| rx_last | input | 1 | Final response byte |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure, valid with done |
| rdata | output | 32 | Read result, valid with done |

## Verification
The assertions take for granted that the frame sink may stall at any point. They also assume a new frame is only started once the previous one has fully left. That holds because commands are offered only while `cmd_ready` is high. They further assume that every response stream ends with `rx_last`. The stimulus offers each command for a single cycle of `cmd_ready`, drives `tx_ready` at random, and sends responses only as complete, contiguous byte streams.

// File: rtl/mgc_pkg.sv
package mgc_pkg;
  localparam int FRAME_BYTES  = 60;
  localparam int SEQ_W        = 31;
  localparam int ADDR_W       = 18;
  localparam int HDR_BYTES    = 14;
  localparam int MAX_LEN      = 4;
  localparam int RESP_LEN_MAX = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} txn_st_t;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [2:0]        len;
    logic [31:0]       wdata;
    logic [SEQ_W-1:0]  seq;
  } req_t;

  typedef struct packed {
    logic [3:0]       len;
    logic [SEQ_W-1:0] seq;
    logic [31:0]      data;
  } resp_t;
endpackage

// File: rtl/mgc_frame_tx.sv
module mgc_frame_tx
  import mgc_pkg::*;
#(
  parameter logic [3:0] PORT_SEL = 4'd0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  req_t       req,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  input  logic       tx_ready,
  output logic       sent
);
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_nxt;

  function automatic logic [7:0] byte_at(input logic [IDX_W-1:0] i, input req_t r);
    logic [7:0] b;
    b = 8'h00;
    case (i)
      IDX_W'(0):  b = {1'b0, 1'b1, 2'b01, PORT_SEL};
      IDX_W'(1):  b = 8'h05;
      IDX_W'(2):  b = r.addr[7:0];
      IDX_W'(3):  b = r.addr[15:8];
      IDX_W'(4):  b = {1'b0, r.len, 2'b00, r.addr[17:16]};
      IDX_W'(5):  b = {3'b101, r.rd, 4'h0};
      IDX_W'(6):  b = {r.seq[6:0], 1'b0};
      IDX_W'(7):  b = r.seq[14:7];
      IDX_W'(8):  b = r.seq[22:15];
      IDX_W'(9):  b = r.seq[30:23];
      IDX_W'(10): b = (!r.rd && r.len > 3'd0) ? r.wdata[7:0]   : 8'h00;
      IDX_W'(11): b = (!r.rd && r.len > 3'd1) ? r.wdata[15:8]  : 8'h00;
      IDX_W'(12): b = (!r.rd && r.len > 3'd2) ? r.wdata[23:16] : 8'h00;
      IDX_W'(13): b = (!r.rd && r.len > 3'd3) ? r.wdata[31:24] : 8'h00;
      default:    b = 8'h00;
    endcase
    return b;
  endfunction

  assign idx_nxt = idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    sent <= 1'b0;
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
      tx_last  <= 1'b0;
      idx      <= '0;
    end else if (start) begin
      tx_valid <= 1'b1;
      tx_data  <= byte_at('0, req);
      tx_last  <= 1'b0;
      idx      <= '0;
    end else if (tx_valid && tx_ready) begin
      if (idx == LAST_IDX) begin
        tx_valid <= 1'b0;
        tx_data  <= 8'h00;
        tx_last  <= 1'b0;
        sent     <= 1'b1;
      end else begin
        idx     <= idx_nxt;
        tx_data <= byte_at(idx_nxt, req);
        tx_last <= (idx_nxt == LAST_IDX);
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst) (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R6
  AST_SENT_AFTER_LAST: assert property (@(posedge clk) disable iff (rst) sent |-> $past(tx_valid && tx_ready && tx_last)); // R5
endmodule

// File: rtl/mgc_resp_rx.sv
module mgc_resp_rx
  import mgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_last,
  output logic       resp_valid,
  output resp_t      resp
);
  localparam int CNT_W = $clog2(HDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(HDR_BYTES);

  logic [CNT_W-1:0] cnt;
  logic             fire_q;
  logic [3:0]       len_q;
  logic [6:0]       s0_q;
  logic [7:0]       s1_q, s2_q, s3_q;
  logic [7:0]       d0_q, d1_q, d2_q, d3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      fire_q <= 1'b0;
      len_q  <= '0;
      s0_q   <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      d2_q   <= '0;
      d3_q   <= '0;
    end else begin
      fire_q <= rx_valid && rx_last;
      if (fire_q) begin
        len_q <= '0;
        s0_q  <= '0;
        s1_q  <= '0;
        s2_q  <= '0;
        s3_q  <= '0;
        d0_q  <= '0;
        d1_q  <= '0;
        d2_q  <= '0;
        d3_q  <= '0;
      end
      if (rx_valid) begin
        case (cnt)
          CNT_W'(4):  len_q <= rx_data[7:4];
          CNT_W'(6):  s0_q  <= rx_data[7:1];
          CNT_W'(7):  s1_q  <= rx_data;
          CNT_W'(8):  s2_q  <= rx_data;
          CNT_W'(9):  s3_q  <= rx_data;
          CNT_W'(10): d0_q  <= rx_data;
          CNT_W'(11): d1_q  <= rx_data;
          CNT_W'(12): d2_q  <= rx_data;
          CNT_W'(13): d3_q  <= rx_data;
          default: ;
        endcase
        if (rx_last)             cnt <= '0;
        else if (cnt != CNT_SAT) cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    resp_valid = fire_q;
    resp.len   = len_q;
    resp.seq   = {s3_q, s2_q, s1_q, s0_q};
    resp.data  = {(len_q > 4'd3) ? d3_q : 8'h00,
                  (len_q > 4'd2) ? d2_q : 8'h00,
                  (len_q > 4'd1) ? d1_q : 8'h00,
                  (len_q > 4'd0) ? d0_q : 8'h00};
  end

  AST_RESP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst) resp_valid |-> $past(rx_valid && rx_last)); // R8
endmodule

// File: rtl/mgc_txn_ctrl.sv
module mgc_txn_ctrl
  import mgc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000,
  parameter int MAX_TRIES   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [3:0]        cmd_len,
  input  logic [31:0]       cmd_wdata,
  output logic              start,
  output req_t              req,
  input  logic              sent,
  input  logic              resp_valid,
  input  resp_t             resp,
  output logic              done,
  output logic              error,
  output logic [31:0]       rdata
);
  localparam int TMR_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST  = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [TRY_W-1:0] TRY_LAST  = TRY_W'(MAX_TRIES);
  localparam logic [ADDR_W-1:0] ADDR_MSK = ~ADDR_W'(3);

  txn_st_t          st;
  logic [TMR_W-1:0] tmr;
  logic [TRY_W-1:0] tries;
  logic [2:0]       len_c;
  logic             is_reset_wr;
  logic             resp_keep;
  logic             read_match;

  always_comb begin
    cmd_ready   = (st == ST_IDLE);
    len_c       = (cmd_len > 4'(MAX_LEN)) ? 3'(MAX_LEN) : cmd_len[2:0];
    is_reset_wr = !req.rd && (req.addr == '0) && req.wdata[31];
    resp_keep   = resp_valid && (resp.len <= 4'(RESP_LEN_MAX)) && (resp.seq >= req.seq);
    read_match  = (resp.seq == req.seq) && (resp.len == {1'b0, req.len});
  end

  always_ff @(posedge clk) begin
    start <= 1'b0;
    done  <= 1'b0;
    if (rst) begin
      st    <= ST_IDLE;
      req   <= '0;
      tmr   <= '0;
      tries <= '0;
      error <= 1'b0;
      rdata <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            req.rd    <= cmd_read;
            req.addr  <= cmd_addr & ADDR_MSK;
            req.len   <= len_c;
            req.wdata <= cmd_wdata;
            req.seq   <= req.seq + SEQ_W'(1);
            tries     <= TRY_W'(1);
            start     <= 1'b1;
            st        <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (sent) begin
            if (is_reset_wr) begin
              done  <= 1'b1;
              error <= 1'b0;
              rdata <= '0;
              st    <= ST_IDLE;
            end else begin
              tmr <= '0;
              st  <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (resp_keep) begin
            done <= 1'b1;
            st   <= ST_IDLE;
            if (!req.rd) begin
              error <= 1'b0;
              rdata <= '0;
            end else if (read_match) begin
              error <= 1'b0;
              rdata <= resp.data;
            end else begin
              error <= 1'b1;
              rdata <= '0;
            end
          end else if (tmr == TMR_LAST) begin
            if (tries == TRY_LAST) begin
              done  <= 1'b1;
              error <= 1'b1;
              rdata <= '0;
              st    <= ST_IDLE;
            end else begin
              tries <= tries + TRY_W'(1);
              start <= 1'b1;
              st    <= ST_SEND;
            end
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst) (start && $past(cmd_valid && cmd_ready)) |-> (req.seq == $past(req.seq) + SEQ_W'(1))); // R4
  AST_RETRY_SAME: assert property (@(posedge clk) disable iff (rst) (start && !$past(cmd_valid && cmd_ready)) |-> $stable(req)); // R7
  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (rst) tries <= TRY_LAST); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> cmd_ready); // R12
endmodule

// File: rtl/mgmt_hdr_codec.sv
module mgmt_hdr_codec
  import mgc_pkg::*;
#(
  parameter int         TIMEOUT_CYC = 1000,
  parameter int         MAX_TRIES   = 3,
  parameter logic [3:0] PORT_SEL    = 4'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_read,
  input  logic [17:0] cmd_addr,
  input  logic [3:0]  cmd_len,
  input  logic [31:0] cmd_wdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        done,
  output logic        error,
  output logic [31:0] rdata
);
  logic  start;
  logic  sent;
  req_t  req;
  logic  resp_valid;
  resp_t resp;

  mgc_txn_ctrl #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .MAX_TRIES  (MAX_TRIES)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_read  (cmd_read),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_wdata (cmd_wdata),
    .start     (start),
    .req       (req),
    .sent      (sent),
    .resp_valid(resp_valid),
    .resp      (resp),
    .done      (done),
    .error     (error),
    .rdata     (rdata)
  );

  mgc_frame_tx #(
    .PORT_SEL(PORT_SEL)
  ) tx_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .req     (req),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .tx_last (tx_last),
    .tx_ready(tx_ready),
    .sent    (sent)
  );

  mgc_resp_rx rx_i (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_last   (rx_last),
    .resp_valid(resp_valid),
    .resp      (resp)
  );
endmodule

// File: tb/mgmt_hdr_codec_tb_top.sv
`timescale 1ns/1ps
module mgmt_hdr_codec_tb_top;
  localparam int TMO = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_read = 1'b0;
  logic [17:0] cmd_addr = '0;
  logic [3:0]  cmd_len = '0;
  logic [31:0] cmd_wdata = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic        done;
  logic        error;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int frames = 0;
  int cur_n = 0;
  int last_n = 0;
  logic [7:0] cur [0:63];
  logic [7:0] lastf [0:63];
  logic [30:0] exp_seq = '0;
  bit   rand_ready = 1'b0;
  bit   prev_stall = 1'b0;
  logic [7:0] prev_data = '0;

  always #2.5 clk = ~clk;

  mgmt_hdr_codec #(.TIMEOUT_CYC(TMO), .MAX_TRIES(3), .PORT_SEL(4'd0)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .done(done), .error(error), .rdata(rdata));

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Sink: picks tx_ready, records bytes taken at the next rising edge (R6 hold check)
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        n_chk++;
        if (!tx_valid || tx_data != prev_data) begin
          n_fail++;
          $display("FAIL R6 hold: actual %0h expected %0h", tx_data, prev_data);
        end
      end
      tx_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (tx_valid && tx_ready) begin
        if (cur_n < 64) cur[cur_n] = tx_data;
        cur_n++;
        if (tx_last) begin
          for (int k = 0; k < 64; k++) lastf[k] = cur[k];
          last_n = cur_n;
          cur_n  = 0;
          frames++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      report();
      $finish;
    end
  end

  function automatic logic [7:0] exp_byte(input int i, input bit rd, input logic [17:0] a,
                                          input int len, input logic [31:0] wd, input logic [30:0] sq);
    int lc;
    logic [3:0] l4;
    lc = (len > 4) ? 4 : len;
    l4 = lc[3:0];
    case (i)
      0: return 8'h50;
      1: return 8'h05;
      2: return {a[7:2], 2'b00};
      3: return a[15:8];
      4: return {l4, 2'b00, a[17:16]};
      5: return rd ? 8'hB0 : 8'hA0;
      6: return {sq[6:0], 1'b0};
      7: return sq[14:7];
      8: return sq[22:15];
      9: return sq[30:23];
      default: begin
        if (i >= 10 && i < 14 && !rd && (i - 10) < lc) return wd[8*(i-10) +: 8];
        return 8'h00;
      end
    endcase
  endfunction

  task automatic issue(input bit rd, input logic [17:0] a, input logic [3:0] len, input logic [31:0] wd);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_read = rd; cmd_addr = a; cmd_len = len; cmd_wdata = wd;
    exp_seq = exp_seq + 31'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int t = 0;
    while (frames < n && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic check_frame(input string tag, input bit rd, input logic [17:0] a,
                             input int len, input logic [31:0] wd, input logic [30:0] sq);
    int bad = -1;
    for (int k = 0; k < 60; k++)
      if (bad < 0 && lastf[k] !== exp_byte(k, rd, a, len, wd, sq)) bad = k;
    check(last_n == 60, {tag, " frame length"}, last_n, 60);
    if (bad >= 0) check(1'b0, $sformatf("%s byte %0d", tag, bad), lastf[bad], exp_byte(bad, rd, a, len, wd, sq));
    else check(1'b1, tag, 0, 0);
  endtask

  task automatic send_resp(input logic [3:0] len, input logic [30:0] sq, input logic [31:0] d);
    logic [7:0] rb [0:13];
    for (int k = 0; k < 14; k++) rb[k] = 8'h00;
    rb[0] = 8'h50; rb[1] = 8'h05; rb[4] = {len, 4'h0};
    rb[6] = {sq[6:0], 1'b1}; rb[7] = sq[14:7]; rb[8] = sq[22:15]; rb[9] = sq[30:23];
    rb[10] = d[7:0]; rb[11] = d[15:8]; rb[12] = d[23:16]; rb[13] = d[31:24];
    for (int k = 0; k < 14; k++) begin
      rx_valid = 1'b1; rx_data = rb[k]; rx_last = (k == 13);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
  endtask

  task automatic wait_done(input int limit, output bit got, output bit err, output logic [31:0] rd);
    got = 1'b0; err = 1'b0; rd = '0;
    for (int t = 0; t < limit && !got; t++) begin
      if (done) begin got = 1'b1; err = error; rd = rdata; end
      else @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    bit got, err;
    logic [31:0] rv;
    int f0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(cmd_ready == 1'b1, "R12 reset cmd_ready", cmd_ready, 1);
    check(tx_valid == 1'b0 && done == 1'b0, "R12 reset tx_valid/done", {tx_valid, done}, 0);

    // R12: response while idle has no effect
    send_resp(4'd4, exp_seq + 31'd1, 32'h12345678);
    wait_done(20, got, err, rv);
    check(!got && cmd_ready, "R12 idle response ignored", got, 0);

    // R1 R2 R3 R4 R5 R9: directed read
    f0 = frames;
    issue(1'b1, 18'h3ABCF, 4'd4, 32'hFFFF_FFFF);
    check(!cmd_ready, "R12 busy cmd_ready low", cmd_ready, 0);
    wait_frames(f0 + 1);
    check_frame("R1 R2 R3 R4 R5 read frame", 1'b1, 18'h3ABCF, 4, 0, exp_seq);
    send_resp(4'd4, exp_seq, 32'hDEADBEEF);
    wait_done(50, got, err, rv);
    check(got && !err && rv == 32'hDEADBEEF, "R9 read result", rv, 32'hDEADBEEF);

    // R3 R5 R10: write with clamped length
    rand_ready = 1'b1;
    f0 = frames;
    issue(1'b0, 18'h01234, 4'd9, 32'h11223344);
    wait_frames(f0 + 1);
    check_frame("R3 R5 clamp write frame", 1'b0, 18'h01234, 9, 32'h11223344, exp_seq);
    send_resp(4'd0, exp_seq, 32'h0);
    wait_done(50, got, err, rv);
    check(got && !err, "R10 write ack", {got, err}, 2'b10);

    // R5: short write
    f0 = frames;
    issue(1'b0, 18'h2FFF0, 4'd2, 32'hCAFEBABE);
    wait_frames(f0 + 1);
    check_frame("R5 two-byte write frame", 1'b0, 18'h2FFF0, 2, 32'hCAFEBABE, exp_seq);
    send_resp(4'd2, exp_seq, 32'h0);
    wait_done(50, got, err, rv);
    check(got && !err, "R10 short write ack", {got, err}, 2'b10);

    // R8 discards, then R9 partial read
    f0 = frames;
    issue(1'b1, 18'h00100, 4'd2, 32'h0);
    wait_frames(f0 + 1);
    send_resp(4'd11, exp_seq, 32'h55555555);
    wait_done(20, got, err, rv);
    check(!got, "R8 long length discarded", got, 0);
    send_resp(4'd2, exp_seq - 31'd1, 32'h66666666);
    wait_done(20, got, err, rv);
    check(!got, "R8 old sequence discarded", got, 0);
    send_resp(4'd2, exp_seq, 32'hAABBCCDD);
    wait_done(50, got, err, rv);
    check(got && !err && rv == 32'h0000CCDD, "R9 two-byte read", rv, 32'h0000CCDD);

    // R9: length mismatch ends in error
    f0 = frames;
    issue(1'b1, 18'h00200, 4'd4, 32'h0);
    wait_frames(f0 + 1);
    send_resp(4'd3, exp_seq, 32'h01020304);
    wait_done(50, got, err, rv);
    check(got && err && rv == 32'h0, "R9 length mismatch error", {got, err}, 2'b11);

    // R7: timeout, three identical transmissions, then error
    f0 = frames;
    issue(1'b1, 18'h00444, 4'd4, 32'h0);
    wait_frames(f0 + 1);
    check_frame("R7 first transmission", 1'b1, 18'h00444, 4, 0, exp_seq);
    wait_frames(f0 + 2);
    check_frame("R7 second transmission same seq", 1'b1, 18'h00444, 4, 0, exp_seq);
    wait_frames(f0 + 3);
    check_frame("R7 third transmission same seq", 1'b1, 18'h00444, 4, 0, exp_seq);
    wait_done(TMO + 50, got, err, rv);
    check(got && err, "R7 timeout error", {got, err}, 2'b11);
    check(frames == f0 + 3, "R7 transmission count", frames - f0, 3);

    // R4: next command uses next sequence, not bumped by retries
    f0 = frames;
    issue(1'b1, 18'h00008, 4'd1, 32'h0);
    wait_frames(f0 + 1);
    check_frame("R4 sequence after retries", 1'b1, 18'h00008, 1, 0, exp_seq);
    send_resp(4'd1, exp_seq, 32'h000000A5);
    wait_done(50, got, err, rv);
    check(got && !err && rv == 32'hA5, "R9 one-byte read", rv, 32'hA5);

    // R11: reset write completes without response
    f0 = frames;
    issue(1'b0, 18'h00002, 4'd4, 32'h8000_0001);
    wait_done(400, got, err, rv);
    check(got && !err && frames == f0 + 1, "R11 reset write no echo", {got, err}, 2'b10);
    // write to 0 without bit 31 waits for a response
    f0 = frames;
    issue(1'b0, 18'h00000, 4'd4, 32'h0000_0001);
    wait_frames(f0 + 1);
    wait_done(30, got, err, rv);
    check(!got, "R11 plain write to zero waits", got, 0);
    send_resp(4'd4, exp_seq, 32'h0);
    wait_done(50, got, err, rv);
    check(got && !err, "R10 write to zero ack", {got, err}, 2'b10);

    // Random traffic
    for (int it = 0; it < 20; it++) begin
      bit rd;
      logic [17:0] a;
      logic [3:0] ln;
      logic [31:0] wd, dat, expd;
      int lc;
      rd = $urandom % 2;
      a = 18'($urandom);
      ln = 4'($urandom);
      wd = $urandom;
      dat = $urandom;
      if (!rd && a[17:2] == 16'h0) a[2] = 1'b1;
      lc = (ln > 4) ? 4 : int'(ln);
      expd = 32'h0;
      for (int k = 0; k < 4; k++) if (k < lc) expd[8*k +: 8] = dat[8*k +: 8];
      f0 = frames;
      issue(rd, a, ln, wd);
      wait_frames(f0 + 1);
      check_frame("R2 R3 R4 R5 random frame", rd, a, int'(ln), wd, exp_seq);
      send_resp(4'(lc), exp_seq, dat);
      wait_done(50, got, err, rv);
      if (rd) check(got && !err && rv == expd, "R9 random read", rv, expd);
      else    check(got && !err, "R10 random write", {got, err}, 2'b10);
    end

    report();
    $finish;
  end
endmodule